// File: doc/BRIEF.md
# Clock and Reset Control Register Block

This block is the software-visible register file of a power, reset and clock controller. A host reaches it over a simple 32-bit bus made of an address, a write strobe, write data, a read strobe, byte enables and read data. It holds nine registers:

- the reference oscillator setup
- setup words for three PLLs: core, memory and network
- a second setup word for the memory PLL and one for the network PLL
- a core clock source select
- a peripheral reset word
- a clock switch status word

Each register's current contents drive an output port of its own, for use by the logic downstream.

No oscillator or PLL is modelled. The status bits that such hardware would report are emulated instead. Whatever value is written, the oscillator reports ready, and every PLL reports both locked and set to internal feedback. Reads are combinational and appear in the same cycle as the read strobe. A write updates its register at the next rising clock edge.

Top module: `clkrst_csr`

## Requirements
- R1: On synchronous active-high reset the registers take these values:
  - oscillator setup: 0xC000_0000 (bit 31 ready, bit 30 enable)
  - each PLL primary setup: 0x8201_87C1. This is made of a reference divider of 1 in bits 5:0, a feedback divider of 31 in bits 14:6 and an output divider of 3 in bits 17:15, plus internal feedback (bit 25) and lock (bit 31).
  - clock select: 0x0000_0001 (bit 0 selects the high-frequency reference)
  - all other registers: zero
- R2: A valid write to the oscillator setup register at offset 0x00 stores the written data with bit 31 (ready) forced to one.
- R3: A valid write to a PLL primary setup register stores the written data with bit 31 (lock) and bit 25 (internal feedback) forced to one. The registers are core at 0x04, memory at 0x0C and network at 0x1C.
- R4: A valid write to any of these registers stores all 32 bits unchanged:
  - memory PLL secondary (0x10)
  - network PLL secondary (0x20)
  - clock select (0x24)
  - peripheral reset (0x28)
  - clock switch status (0x2C)
- R5: While the read strobe is high, the read data shows the addressed register in the same cycle. While the read strobe is low, the read data is zero.
- R6: An address that matches none of the nine offsets reads as zero, and a write to it changes no register. This covers the gaps 0x08, 0x14 and 0x18, offsets above 0x2C, and addresses that are not word aligned.
- R7: An access is valid only when all four byte enables are set. A write with any other byte enable pattern changes no register, and a read with one returns zero.
- R8: A valid write shows on the register's output port after exactly one rising clock edge. Writes to one register never change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| osc_cfg_q | output | 32 | Oscillator setup register |
| pll_core_q | output | 32 | Core PLL primary setup |
| pll_mem_q | output | 32 | Memory PLL primary setup |
| pll_mem2_q | output | 32 | Memory PLL secondary setup |
| pll_net_q | output | 32 | Network PLL primary setup |
| pll_net2_q | output | 32 | Network PLL secondary setup |
| clk_sel_q | output | 32 | Core clock select |
| dev_rst_q | output | 32 | Peripheral reset word |
| mux_stat_q | output | 32 | Clock switch status |

## Verification
The hardest case to reach is a write that tries to clear a forced status bit, with the bit still reading back as one. Random data seldom clears bits 31 and 25 together. The stimulus therefore writes all zeros, and then all ones, to every mapped offset.

The other hard case is a write that is silently dropped. Addresses are drawn partly from the gaps in the map and from unaligned offsets, and byte enables are drawn with partial patterns. After each dropped write, all nine register outputs are compared with the model.

// File: rtl/clkrst_csr_pkg.sv
package clkrst_csr_pkg;
  localparam int NREG = 9;
  localparam int DW   = 32;
  localparam int BE_W = DW / 8;

  // register indices
  localparam int IX_OSC   = 0;
  localparam int IX_CPLL  = 1;
  localparam int IX_MPLL  = 2;
  localparam int IX_MPLL2 = 3;
  localparam int IX_NPLL  = 4;
  localparam int IX_NPLL2 = 5;
  localparam int IX_SEL   = 6;
  localparam int IX_DRST  = 7;
  localparam int IX_MUX   = 8;

  localparam int OSC_RDY_BIT  = 31;
  localparam int OSC_EN_BIT   = 30;
  localparam int PLL_LOCK_BIT = 31;
  localparam int PLL_FSE_BIT  = 25;

  localparam logic [5:0] DIV_REF_DEF = 6'd1;
  localparam logic [8:0] DIV_FB_DEF  = 9'd31;
  localparam logic [2:0] DIV_OUT_DEF = 3'd3;

  function automatic logic [7:0] reg_offset(input int i);
    case (i)
      IX_OSC:   return 8'h00;
      IX_CPLL:  return 8'h04;
      IX_MPLL:  return 8'h0C;
      IX_MPLL2: return 8'h10;
      IX_NPLL:  return 8'h1C;
      IX_NPLL2: return 8'h20;
      IX_SEL:   return 8'h24;
      IX_DRST:  return 8'h28;
      default:  return 8'h2C;
    endcase
  endfunction

  function automatic bit is_pll_primary(input int i);
    return (i == IX_CPLL) || (i == IX_MPLL) || (i == IX_NPLL);
  endfunction

  function automatic logic [DW-1:0] reg_force(input int i);
    logic [DW-1:0] m;
    m = '0;
    if (i == IX_OSC) m[OSC_RDY_BIT] = 1'b1;
    if (is_pll_primary(i)) begin
      m[PLL_LOCK_BIT] = 1'b1;
      m[PLL_FSE_BIT]  = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] reg_reset(input int i);
    logic [DW-1:0] v;
    v = '0;
    if (i == IX_OSC) begin
      v[OSC_RDY_BIT] = 1'b1;
      v[OSC_EN_BIT]  = 1'b1;
    end
    if (is_pll_primary(i)) begin
      v[5:0]   = DIV_REF_DEF;
      v[14:6]  = DIV_FB_DEF;
      v[17:15] = DIV_OUT_DEF;
      v = v | reg_force(i);
    end
    if (i == IX_SEL) v[0] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clkrst_csr_decode.sv
module clkrst_csr_decode
  import clkrst_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic [NREG-1:0]   sel,
  output logic              hit
);
  logic full_word;
  assign full_word = &be;

  for (genvar g = 0; g < NREG; g++) begin : g_match
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(reg_offset(g));
    assign sel[g] = full_word && (addr == OFS);
  end

  assign hit = |sel;
endmodule

// File: rtl/clkrst_csr_regs.sv
module clkrst_csr_regs
  import clkrst_csr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [NREG-1:0]          sel,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] FORCE = reg_force(g);
    localparam logic [DW-1:0] RSTV  = reg_reset(g);

    always_ff @(posedge clk) begin
      if (rst)                q[g] <= RSTV;
      else if (wr && sel[g])  q[g] <= wdata | FORCE;
    end

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> q[g] == RSTV);                              // R1
    AST_FORCED_SET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) == 1'b0 |-> (q[g] & FORCE) == FORCE);           // R3
  end
endmodule

// File: rtl/clkrst_csr_rmux.sv
module clkrst_csr_rmux
  import clkrst_csr_pkg::*;
(
  input  logic                     rd,
  input  logic [NREG-1:0]          sel,
  input  logic [NREG-1:0][DW-1:0]  q,
  output logic [DW-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd && sel[i]) rdata = rdata | q[i];
    end
  end
endmodule

// File: rtl/clkrst_csr.sv
module clkrst_csr
  import clkrst_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       osc_cfg_q,
  output logic [31:0]       pll_core_q,
  output logic [31:0]       pll_mem_q,
  output logic [31:0]       pll_mem2_q,
  output logic [31:0]       pll_net_q,
  output logic [31:0]       pll_net2_q,
  output logic [31:0]       clk_sel_q,
  output logic [31:0]       dev_rst_q,
  output logic [31:0]       mux_stat_q
);
  logic [NREG-1:0]         sel;
  logic                    hit;
  logic [NREG-1:0][DW-1:0] q;

  clkrst_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .be   (bus_be),
    .sel  (sel),
    .hit  (hit)
  );

  clkrst_csr_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .sel   (sel),
    .wdata (bus_wdata),
    .q     (q)
  );

  clkrst_csr_rmux u_rmux (
    .rd    (bus_rd),
    .sel   (sel),
    .q     (q),
    .rdata (bus_rdata)
  );

  assign osc_cfg_q  = q[IX_OSC];
  assign pll_core_q = q[IX_CPLL];
  assign pll_mem_q  = q[IX_MPLL];
  assign pll_mem2_q = q[IX_MPLL2];
  assign pll_net_q  = q[IX_NPLL];
  assign pll_net2_q = q[IX_NPLL2];
  assign clk_sel_q  = q[IX_SEL];
  assign dev_rst_q  = q[IX_DRST];
  assign mux_stat_q = q[IX_MUX];

  localparam logic [31:0] OSC_RDY_MASK = 32'h1 << OSC_RDY_BIT;

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> $stable(q));                            // R6
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |-> bus_rdata == 32'h0);                    // R6
  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_be != 4'hF) |=> $stable(q));                  // R7
  AST_OSC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_be == 4'hF && bus_addr == '0)
      |=> osc_cfg_q == ($past(bus_wdata) | OSC_RDY_MASK));       // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(q));                                     // R8
endmodule

// File: tb/clkrst_csr_bench.sv
module clkrst_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] o_osc, o_cpll, o_mpll, o_mpll2, o_npll, o_npll2, o_sel, o_drst, o_mux;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] model [9];

  always #4 clk = ~clk;

  clkrst_csr u_clkrst_csr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .osc_cfg_q(o_osc), .pll_core_q(o_cpll),
    .pll_mem_q(o_mpll), .pll_mem2_q(o_mpll2), .pll_net_q(o_npll),
    .pll_net2_q(o_npll2), .clk_sel_q(o_sel), .dev_rst_q(o_drst),
    .mux_stat_q(o_mux)
  );

  function automatic int addr_index(input logic [7:0] a);
    case (a)
      8'h00: return 0;  8'h04: return 1;  8'h0C: return 2;
      8'h10: return 3;  8'h1C: return 4;  8'h20: return 5;
      8'h24: return 6;  8'h28: return 7;  8'h2C: return 8;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] index_addr(input int i);
    logic [7:0] t [9] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C};
    return t[i];
  endfunction

  function automatic logic [31:0] forced(input int i);
    if (i == 0) return 32'h8000_0000;
    if (i == 1 || i == 2 || i == 4) return 32'h8200_0000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] reset_val(input int i);
    if (i == 0) return 32'hC000_0000;
    if (i == 1 || i == 2 || i == 4) return 32'h8201_87C1;
    if (i == 6) return 32'h0000_0001;
    return 32'h0;
  endfunction

  function automatic logic [31:0] out_of(input int i);
    case (i)
      0: return o_osc;   1: return o_cpll;  2: return o_mpll;
      3: return o_mpll2; 4: return o_npll;  5: return o_npll2;
      6: return o_sel;   7: return o_drst;  default: return o_mux;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < 9; i++) check(tag, out_of(i), model[i]);
  endtask

  // one bus cycle: drive at negedge, check read combinationally,
  // then check register outputs just after the capturing edge
  task automatic op(input bit wr, input bit rd, input logic [7:0] a,
                    input logic [3:0] be, input logic [31:0] d, input string tag);
    int idx;
    logic [31:0] rexp;
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    #1;
    idx = addr_index(a);
    rexp = (rd && be == 4'hF && idx >= 0) ? model[idx] : 32'h0;
    check(tag, bus_rdata, rexp);
    @(posedge clk);
    #1;
    if (wr && be == 4'hF && idx >= 0) model[idx] = d | forced(idx);
    check_outputs(tag);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    for (int i = 0; i < 9; i++) model[i] = reset_val(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check_outputs("R1 reset");
    for (int i = 0; i < 9; i++) op(0, 1, index_addr(i), 4'hF, 32'h0, "R1 reset readback");

    // all zeros and all ones: forced bits survive
    for (int i = 0; i < 9; i++) op(1, 0, index_addr(i), 4'hF, 32'h0, "R2 R3 R4 zeros");
    for (int i = 0; i < 9; i++) op(0, 1, index_addr(i), 4'hF, 32'h0, "R2 R3 R5 zeros readback");
    check("R2 osc ready", o_osc, 32'h8000_0000);
    check("R3 core pll", o_cpll, 32'h8200_0000);
    for (int i = 0; i < 9; i++) op(1, 1, index_addr(i), 4'hF, 32'hFFFF_FFFF, "R4 R8 ones");
    check("R4 plain ones", o_drst, 32'hFFFF_FFFF);

    // strobe low reads zero
    op(0, 0, 8'h00, 4'hF, 32'h0, "R5 idle read zero");
    // unmapped gaps, beyond map, misaligned
    op(1, 1, 8'h08, 4'hF, 32'h1234_5678, "R6 gap 08");
    op(1, 1, 8'h14, 4'hF, 32'h0, "R6 gap 14");
    op(1, 1, 8'h18, 4'hF, 32'h0, "R6 gap 18");
    op(1, 1, 8'h30, 4'hF, 32'h0, "R6 beyond");
    op(1, 1, 8'h05, 4'hF, 32'h0, "R6 misaligned");
    // partial byte enables
    op(1, 1, 8'h28, 4'h3, 32'h0, "R7 half word");
    op(1, 1, 8'h00, 4'h1, 32'h0, "R7 byte");
    op(1, 1, 8'h24, 4'h0, 32'h0, "R7 none");
    // pattern writes to each register
    op(1, 0, 8'h24, 4'hF, 32'hA5A5_5A5A, "R4 clock select");
    op(1, 0, 8'h1C, 4'hF, 32'h0000_0F0F, "R3 net pll");
    op(1, 0, 8'h00, 4'hF, 32'h0000_0001, "R2 osc");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(0, 3) != 0) a = index_addr($urandom_range(0, 8));
      else a = 8'($urandom_range(0, 63));
      be = ($urandom_range(0, 4) != 0) ? 4'hF : 4'($urandom_range(0, 14));
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, be, d, "R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule